// File: doc/BRIEF.md
# Queued Single-Byte I2C Master

This block is a single-master I2C controller for short on-board links. The host posts a request by pulsing a strobe together with a 7-bit target address, a read/write flag and one write byte. The request is stored in a small queue. A single sequencer takes requests from the queue one at a time and carries out each one as a complete bus transfer. A transfer is START, the address byte, the acknowledge, one data byte, the acknowledge, then STOP.

The sequencer also does three other jobs. It divides the system clock down to the serial clock. It shares one 3-bit counter between the address bits and the data bits. It shapes the START and STOP conditions. When a read finishes, the received byte is presented with a one-cycle valid pulse. When the target does not acknowledge, the transfer is cut short with STOP and a one-cycle error pulse. Both bus lines are open-drain. The block only asserts a pull-low enable for each line and reads the wired SDA level back.

Top module: `i2cq_master`

## Requirements
- R1: Each request strobed while the queue is not full is stored as {7-bit address, 8-bit data, direction}. Stored requests are carried out on the bus strictly in arrival order, one transfer per request.
- R2: The queue holds at most QDEPTH-1 requests. `q_full` is high exactly when that many are held. A strobe while `q_full` is high stores nothing and causes no transfer.
- R3: After reset and between transfers, `ready` is high and neither line is pulled low. `ready` is low while a transfer is in progress.
- R4: During a transfer each SCL period lasts DIV system clocks, with SCL released (high) for the second half of each bit.
- R5: A transfer opens with exactly one START (SDA falls while SCL is high) and closes with exactly one STOP (SDA rises while SCL is high). No other SDA change happens while SCL is high.
- R6: The first byte on the bus is the 7-bit address MSB first, then the direction bit (0 = write, 1 = read). SDA changes only while SCL is low.
- R7: On a write whose address is acknowledged, the 8 data bits follow MSB first, then one acknowledge clock, then STOP. That is 18 data-carrying SCL pulses plus the STOP rise.
- R8: On a read whose address is acknowledged, 8 bits are shifted in MSB first. The master pulls SDA low for the ninth clock, then sends STOP. `rd_data` holds the byte and `rd_valid` pulses for one cycle in the first idle cycle after STOP.
- R9: If SDA is high at the address acknowledge, the transfer goes straight to STOP after that ninth clock, with no data clocks. If SDA is high at the write data acknowledge, the transfer also ends with STOP. Either way `nack_err` pulses for one cycle in the first idle cycle after STOP, and `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_strobe | input | 1 | Stores a request when high for one cycle |
| cmd_addr | input | 7 | Target address of the request |
| cmd_rnw | input | 1 | Direction: 1 read, 0 write |
| cmd_wdata | input | 8 | Byte to write (unused for reads) |
| q_full | output | 1 | Queue cannot accept a request |
| ready | output | 1 | Sequencer idle, no transfer in progress |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle pulse: rd_data updated |
| nack_err | output | 1 | One-cycle pulse: transfer ended on missing acknowledge |
| scl_lo | output | 1 | Pull SCL low when 1, release when 0 |
| sda_lo | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Wired level of the SDA line |

## Verification
Two situations are hard to reach from the host side. The first is a queue filled to its limit while the sequencer is busy. The second is the refusal of a further strobe in that state. The stimulus reaches both by strobing on consecutive cycles straight after an idle period. The sequencer drains only the first entry, so the queue fills in four cycles and the fifth strobe lands on a full queue. Acknowledge failures depend on the far end, so a bus-side target model decides them. It ignores foreign addresses and refuses one reserved data value. This exercises both abort paths, and the SCL pulses counted between START and STOP show that no data clocks follow an address refusal.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int BITS_W = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rnw;
    } xfer_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_AACK,
        ST_DATA, ST_DACK, ST_STOP, ST_RDATA
    } st_t;

    typedef enum logic [1:0] {PH_LO_A, PH_LO_B, PH_HI_A, PH_HI_B} ph_t;

    function automatic logic [DATA_W-1:0] addr_byte(input xfer_t x);
        return {x.addr, x.rnw};
    endfunction
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  xfer_t din,
    output logic  full,
    input  logic  pop,
    output xfer_t dout,
    output logic  empty
);
    localparam int AW = $clog2(DEPTH);

    xfer_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign empty   = (wptr == rptr);
    assign full    = ((wptr + AW'(1)) == rptr);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= wptr + AW'(1);
            end
            if (do_pop)
                rptr <= rptr + AW'(1);
        end
    end

    // R2
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push) |=> $stable(wptr));
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
    import i2cq_pkg::*;
#(
    parameter int DIV = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  xfer_t             q_data,
    output logic              q_pop,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              nack_err,
    output logic              scl_lo,
    output logic              sda_lo,
    input  logic              sda_in
);
    localparam int Q  = DIV / 4;
    localparam int QW = (Q > 1) ? $clog2(Q) : 1;

    st_t               st;
    ph_t               ph;
    logic [QW-1:0]     qcnt;
    logic [BITS_W-1:0] bitcnt;
    logic [DATA_W-1:0] shf;
    xfer_t             cur;
    logic              smp, err_pend, tick, bit_end;

    assign tick    = (qcnt == QW'(Q - 1));
    assign bit_end = tick && (ph == PH_HI_B);
    assign ready   = (st == ST_IDLE);
    assign q_pop   = (st == ST_IDLE) && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_LO_A;
            qcnt     <= '0;
            bitcnt   <= '0;
            shf      <= '0;
            cur      <= '0;
            smp      <= 1'b1;
            err_pend <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            nack_err <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            nack_err <= 1'b0;
            if (st == ST_IDLE) begin
                qcnt     <= '0;
                ph       <= PH_LO_A;
                err_pend <= 1'b0;
                if (!q_empty) begin
                    cur <= q_data;
                    st  <= ST_START;
                end
            end else begin
                qcnt <= tick ? '0 : qcnt + QW'(1);
                if (tick) begin
                    ph <= ph_t'(ph + 2'd1);
                    if (ph == PH_HI_A) begin
                        smp <= sda_in;
                        if (st == ST_RDATA)
                            shf <= {shf[DATA_W-2:0], sda_in};
                    end
                end
                if (bit_end) begin
                    unique case (st)
                        ST_START: begin
                            st     <= ST_ADDR;
                            bitcnt <= '1;
                            shf    <= addr_byte(cur);
                        end
                        ST_ADDR: begin
                            if (bitcnt == '0) st <= ST_AACK;
                            else begin
                                bitcnt <= bitcnt - BITS_W'(1);
                                shf    <= {shf[DATA_W-2:0], 1'b0};
                            end
                        end
                        ST_AACK: begin
                            bitcnt <= '1;
                            if (smp) begin
                                err_pend <= 1'b1;
                                st       <= ST_STOP;
                            end else if (cur.rnw) begin
                                st <= ST_RDATA;
                            end else begin
                                st  <= ST_DATA;
                                shf <= cur.data;
                            end
                        end
                        ST_DATA: begin
                            if (bitcnt == '0) st <= ST_DACK;
                            else begin
                                bitcnt <= bitcnt - BITS_W'(1);
                                shf    <= {shf[DATA_W-2:0], 1'b0};
                            end
                        end
                        ST_RDATA: begin
                            if (bitcnt == '0) st <= ST_DACK;
                            else bitcnt <= bitcnt - BITS_W'(1);
                        end
                        ST_DACK: begin
                            if (!cur.rnw && smp) err_pend <= 1'b1;
                            st <= ST_STOP;
                        end
                        ST_STOP: begin
                            st       <= ST_IDLE;
                            nack_err <= err_pend;
                            rd_valid <= cur.rnw && !err_pend;
                            if (cur.rnw && !err_pend) rd_data <= shf;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_IDLE:  begin scl_lo = 1'b0; sda_lo = 1'b0; end
            ST_START: begin
                scl_lo = 1'b0;
                sda_lo = (ph == PH_HI_A) || (ph == PH_HI_B);
            end
            ST_STOP: begin
                scl_lo = (ph == PH_LO_A);
                sda_lo = (ph == PH_LO_A) || (ph == PH_LO_B);
            end
            default: begin
                scl_lo = (ph == PH_LO_A) || (ph == PH_LO_B);
                if (st == ST_ADDR || st == ST_DATA) sda_lo = !shf[DATA_W-1];
                else if (st == ST_DACK)             sda_lo = cur.rnw;
                else                                sda_lo = 1'b0;
            end
        endcase
    end

    // R6
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((st inside {ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_RDATA}) && $stable(st)
         && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo));
    // R5
    start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_START) && $rose(sda_lo)) |-> (!scl_lo && !$past(scl_lo)));
    // R5
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_STOP) && $fell(sda_lo)) |-> (!scl_lo && !$past(scl_lo)));
    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        nack_err |-> (!rd_valid && ready));
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
    import i2cq_pkg::*;
#(
    parameter int DIV    = 512,
    parameter int QDEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_strobe,
    input  logic [6:0] cmd_addr,
    input  logic       cmd_rnw,
    input  logic [7:0] cmd_wdata,
    output logic       q_full,
    output logic       ready,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       nack_err,
    output logic       scl_lo,
    output logic       sda_lo,
    input  logic       sda_in
);
    xfer_t req, head;
    logic  q_empty, q_pop;

    assign req = '{addr: cmd_addr, data: cmd_wdata, rnw: cmd_rnw};

    i2cq_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(cmd_strobe), .din(req), .full(q_full),
        .pop(q_pop), .dout(head), .empty(q_empty)
    );

    i2cq_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst(rst), .q_empty(q_empty), .q_data(head), .q_pop(q_pop),
        .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid), .nack_err(nack_err),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_in)
    );

    // R1
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> !q_empty);
    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !q_empty) |=> !ready);
endmodule

// File: tb/tb_i2cq_master.sv
`timescale 1ns/1ps
module tb_i2cq_master;
    localparam int TB_DIV = 32;
    localparam logic [6:0] SLV = 7'h5A;
    localparam int S_IDLE = 0, S_ADDR = 1, S_AACK = 2, S_WR = 3,
                   S_DACK = 4, S_RD = 5, S_MACK = 6, S_IGN = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_strobe = 1'b0, cmd_rnw = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic q_full, ready, rd_valid, nack_err, scl_lo, sda_lo;
    logic [7:0] rd_data;
    logic slv_lo = 1'b0;
    logic scl_w, sda_w;

    assign scl_w = !scl_lo;
    assign sda_w = !(sda_lo || slv_lo);

    always #4 clk = ~clk;

    i2cq_master #(.DIV(TB_DIV), .QDEPTH(4)) dut (
        .clk(clk), .rst(rst), .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr),
        .cmd_rnw(cmd_rnw), .cmd_wdata(cmd_wdata), .q_full(q_full), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .nack_err(nack_err),
        .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_w)
    );

    typedef struct {
        logic [6:0] addr; logic rnw; logic [7:0] wdata;
        logic err; logic [7:0] rdata; int rises;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0, rd_exp = 0, accepted = 0, seen = 0;

    function automatic logic [7:0] rbyte(input int i);
        return 8'h96 ^ 8'(i * 59);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_req(input logic [6:0] a, input logic r, input logic [7:0] d);
        exp_t e;
        bit ack = (a == SLV);
        e.addr = a; e.rnw = r; e.wdata = d;
        e.err  = !ack || (!r && d == 8'hEE);
        e.rdata = 8'h00;
        if (ack && r) begin e.rdata = rbyte(rd_exp); rd_exp++; end
        e.rises = ack ? 19 : 10;
        exp_q.push_back(e);
        accepted++;
    endtask

    task automatic push(input logic [6:0] a, input logic r, input logic [7:0] d);
        @(negedge clk);
        while (q_full) @(negedge clk);
        cmd_addr = a; cmd_rnw = r; cmd_wdata = d; cmd_strobe = 1'b1;
        expect_req(a, r, d);
        @(negedge clk);
        cmd_strobe = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    // bus-side target model and scoreboard monitor
    int sphase = S_IDLE, bitn = 0, rise_cnt = 0, start_cnt = 0, stop_cnt = 0;
    int cyc = 0, t_r1 = 0, per_last = 0, hi_len = 0, rd_idx = 0;
    logic p_scl = 1'b1, p_sda = 1'b1, p_ready = 1'b1, rnw_s = 1'b0, cap_mack = 1'b1;
    logic [7:0] shreg = '0, cap_abyte = '0, cap_data = '0, rcur = '0;

    always @(negedge clk) begin
        logic c, s;
        exp_t e;
        c = scl_w; s = sda_w; cyc++;
        if (!rst) begin
            if (c && p_scl && p_sda && !s) begin
                start_cnt++; sphase = S_ADDR; bitn = 0; shreg = '0; rise_cnt = 0;
                cap_data = '0; cap_mack = 1'b1;
            end else if (c && p_scl && !p_sda && s) begin
                stop_cnt++; sphase = S_IDLE; slv_lo = 1'b0;
            end else if (c && !p_scl) begin
                rise_cnt++;
                if (rise_cnt == 1) t_r1 = cyc;
                if (rise_cnt == 2) per_last = cyc - t_r1;
                if (sphase == S_ADDR || sphase == S_WR) begin
                    shreg = {shreg[6:0], s}; bitn++;
                end else if (sphase == S_RD) bitn++;
                else if (sphase == S_MACK) cap_mack = s;
            end else if (!c && p_scl) begin
                if (rise_cnt == 1) hi_len = cyc - t_r1;
                case (sphase)
                    S_ADDR: if (bitn == 8) begin
                        cap_abyte = shreg;
                        if (shreg[7:1] == SLV) begin
                            slv_lo = 1'b1; rnw_s = shreg[0]; sphase = S_AACK;
                        end else sphase = S_IGN;
                    end
                    S_AACK: begin
                        slv_lo = 1'b0; bitn = 0; shreg = '0;
                        if (rnw_s) begin
                            rcur = rbyte(rd_idx); rd_idx++;
                            slv_lo = !rcur[7]; sphase = S_RD;
                        end else sphase = S_WR;
                    end
                    S_WR: if (bitn == 8) begin
                        cap_data = shreg; slv_lo = (shreg != 8'hEE); sphase = S_DACK;
                    end
                    S_DACK: begin slv_lo = 1'b0; sphase = S_IGN; end
                    S_RD: if (bitn == 8) begin slv_lo = 1'b0; sphase = S_MACK; end
                          else slv_lo = !rcur[7 - bitn];
                    S_MACK: sphase = S_IGN;
                    default: ;
                endcase
            end
            // monitor: a transfer has just completed
            if (ready && !p_ready) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected transfer", 32'(cap_abyte), 32'hFFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(start_cnt == 1 && stop_cnt == 1, "R5", "start/stop count",
                        32'(start_cnt * 16 + stop_cnt), 32'h11);
                    chk(cap_abyte == {e.addr, e.rnw}, "R1 R6", "address byte",
                        32'(cap_abyte), 32'({e.addr, e.rnw}));
                    chk(per_last == TB_DIV, "R4", "scl period", 32'(per_last), 32'(TB_DIV));
                    chk(hi_len == TB_DIV / 2, "R4", "scl high time", 32'(hi_len), 32'(TB_DIV / 2));
                    chk(rise_cnt == e.rises, "R7 R9", "scl pulses", 32'(rise_cnt), 32'(e.rises));
                    chk(nack_err == e.err, "R9", "nack_err", 32'(nack_err), 32'(e.err));
                    chk(rd_valid == (e.rnw && !e.err), "R8", "rd_valid",
                        32'(rd_valid), 32'(e.rnw && !e.err));
                    if (!e.rnw && e.addr == SLV)
                        chk(cap_data == e.wdata, "R7", "write byte", 32'(cap_data), 32'(e.wdata));
                    if (e.rnw && !e.err) begin
                        chk(rd_data == e.rdata, "R8", "read byte", 32'(rd_data), 32'(e.rdata));
                        chk(cap_mack == 1'b0, "R8", "master ack", 32'(cap_mack), 32'h0);
                    end
                end
                start_cnt = 0; stop_cnt = 0;
            end
        end
        p_scl = c; p_sda = sda_w; p_ready = ready;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        chk(ready == 1'b1, "R3", "ready after reset", 32'(ready), 32'h1);
        chk(!scl_lo && !sda_lo, "R3", "lines released", 32'({scl_lo, sda_lo}), 32'h0);
        chk(q_full == 1'b0 && !rd_valid && !nack_err, "R2", "idle flags",
            32'({q_full, rd_valid, nack_err}), 32'h0);

        push(SLV, 1'b0, 8'h3C);
        repeat (5) @(negedge clk);
        chk(ready == 1'b0, "R3", "ready during transfer", 32'(ready), 32'h0);
        drain();
        chk(ready && !scl_lo && !sda_lo, "R3", "idle after transfer",
            32'({ready, scl_lo, sda_lo}), 32'h4);

        push(SLV, 1'b1, 8'h00);  drain();
        push(7'h11, 1'b0, 8'h55); drain();
        push(7'h11, 1'b1, 8'h00); drain();
        push(SLV, 1'b0, 8'hEE);  drain();
        push(SLV, 1'b0, 8'h00);  drain();
        push(SLV, 1'b0, 8'hFF);  drain();
        push(7'h2D, 1'b1, 8'h00); drain();

        // back-to-back strobes fill the queue (R2)
        @(negedge clk);
        cmd_strobe = 1'b1;
        cmd_addr = SLV;  cmd_rnw = 1'b0; cmd_wdata = 8'hA1; expect_req(SLV, 1'b0, 8'hA1);
        @(negedge clk);
        cmd_addr = SLV;  cmd_rnw = 1'b1; cmd_wdata = 8'h00; expect_req(SLV, 1'b1, 8'h00);
        @(negedge clk);
        cmd_addr = 7'h7F; cmd_rnw = 1'b0; cmd_wdata = 8'h42; expect_req(7'h7F, 1'b0, 8'h42);
        @(negedge clk);
        cmd_addr = SLV;  cmd_rnw = 1'b0; cmd_wdata = 8'h81; expect_req(SLV, 1'b0, 8'h81);
        @(negedge clk);
        chk(q_full == 1'b1, "R2", "full after three held", 32'(q_full), 32'h1);
        cmd_addr = SLV;  cmd_rnw = 1'b0; cmd_wdata = 8'h99;  // refused, no expectation
        @(negedge clk);
        cmd_strobe = 1'b0;
        chk(q_full == 1'b1, "R2", "still full while busy", 32'(q_full), 32'h1);
        drain();
        repeat (3 * TB_DIV * 20) @(negedge clk);
        chk(seen == accepted, "R2", "transfer count", 32'(seen), 32'(accepted));
        chk(q_full == 1'b0 && ready, "R1", "queue drained", 32'({q_full, ready}), 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule